// File: doc/BRIEF.md
# USB Host Controller Register Read Decoder

This block serves the read side of the 32-bit memory-mapped register bank of a USB host controller. A read request carries a byte address; the block decodes the word offset and returns the matching register: control and command status, interrupt state, list pointers, frame timing, root hub descriptors, a window of per-port status words, and four extension registers. The register values arrive as live inputs from the rest of the controller and are sampled when the request is accepted.

Requests and responses are valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The response is presented on the next cycle. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response data is held and no new request is taken. A build-time option byte-swaps every returned word for a big-endian host.

Top module: `hcrd_read_decoder`

## Requirements
- R1: A read whose address bits [1:0] are not both zero returns 0xFFFFFFFF.
- R2: Word offset 0 returns the constant 0x00000010.
- R3: Word offsets 1, 2, 3, 6, 7, 8, 9, 10, 11, 12, 14, 15, 16, 17, 18, 19 and 20 return, in that order, `ctl`, `cmd_status`, `int_status`, `hcca_base`, `per_cur_ed`, `ctrl_head_ed`, `ctrl_cur_ed`, `bulk_head_ed`, `bulk_cur_ed`, `done_head`, `frame_remaining`, `frame_number`, `periodic_start`, `ls_threshold`, `hub_desc_a`, `hub_desc_b` and `hub_status`.
- R4: Word offsets 4 and 5 both return `int_mask`.
- R5: Word offset 13 returns `fi_toggle` in bit 31, `fi_max_pkt` in bits 30:16, zero in bits 15:14 and `fi_interval` in bits 13:0.
- R6: Word offsets 21 to 21+NUM_PORTS-1 (byte 0x54 upward) return the status word of port (offset−21), with bit 8 (port power) forced to 1. Offsets past the last configured port are not port reads.
- R7: Where the port window overlaps offsets 24 to 27, the port status read wins.
- R8: Outside the port window, offset 24 returns `ext_status & ext_mask`, and offsets 25, 26 and 27 return `ext_reset`, `ext_mask` and `ext_test`.
- R9: Any aligned offset not covered by R2 to R8 returns 0xFFFFFFFF.
- R10: With BIG_ENDIAN=1, the final word is returned with its four bytes in reverse order.
- R11: `req_ready` = !`rsp_valid` || `rsp_ready`. An accepted request produces `rsp_valid` on the next cycle. A stalled response keeps its data unchanged.
- R12: After reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request can be taken |
| req_addr | input | ADDR_W | Byte address of the read |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 32 | Read data |
| ctl | input | 32 | Control register |
| cmd_status | input | 32 | Command status register |
| int_status | input | 32 | Interrupt status |
| int_mask | input | 32 | Interrupt enable mask |
| hcca_base | input | 32 | Communication area base |
| per_cur_ed | input | 32 | Periodic current descriptor |
| ctrl_head_ed | input | 32 | Control list head |
| ctrl_cur_ed | input | 32 | Control list current |
| bulk_head_ed | input | 32 | Bulk list head |
| bulk_cur_ed | input | 32 | Bulk list current |
| done_head | input | 32 | Done queue head |
| fi_toggle | input | 1 | Frame interval toggle |
| fi_max_pkt | input | 15 | Largest data packet field |
| fi_interval | input | 14 | Frame interval |
| frame_remaining | input | 32 | Frame remaining |
| frame_number | input | 32 | Frame number |
| periodic_start | input | 32 | Periodic start |
| ls_threshold | input | 32 | Low-speed threshold |
| hub_desc_a | input | 32 | Root hub descriptor A |
| hub_desc_b | input | 32 | Root hub descriptor B |
| hub_status | input | 32 | Root hub status |
| port_status | input | NUM_PORTS*32 | Port status words, port 0 in the low bits |
| ext_status | input | 32 | Extension status |
| ext_reset | input | 32 | Extension reset |
| ext_mask | input | 32 | Extension interrupt mask |
| ext_test | input | 32 | Extension test |

## Verification
The port window covers the extension offsets only when the configuration has four or more ports. With the default three ports, that overlap can never be reached. The bench therefore runs a second instance with five ports and the byte swap enabled, next to the default one. Both instances get the same addresses, so offsets 24 and 25 are seen as extension registers by one instance and as port status by the other. The stalled-response case is reached by holding `rsp_ready` low. During the stall, a second request is pending and the register inputs change.

// File: rtl/hcrd_pkg.sv
package hcrd_pkg;
  localparam int DATA_W      = 32;
  localparam int FI_W        = 14;
  localparam int FMPS_W      = 15;
  localparam int PORT_WORD0  = 21;
  localparam int EXT_LAST    = 27;
  localparam int PWR_BIT     = 8;
  localparam logic [DATA_W-1:0] REV_VALUE = 32'h0000_0010;
  localparam logic [DATA_W-1:0] NO_REG    = 32'hFFFF_FFFF;

  typedef enum logic [4:0] {
    SEL_REV, SEL_CTL, SEL_CMD, SEL_ISTAT, SEL_IMASK, SEL_HCCA, SEL_PCUR,
    SEL_CHEAD, SEL_CCUR, SEL_BHEAD, SEL_BCUR, SEL_DONE, SEL_FINT, SEL_FREM,
    SEL_FNUM, SEL_PSTART, SEL_LSTH, SEL_HDA, SEL_HDB, SEL_HSTAT, SEL_PORT,
    SEL_XSTAT, SEL_XRST, SEL_XMASK, SEL_XTEST, SEL_NONE
  } sel_e;
endpackage

// File: rtl/hcrd_decode.sv
module hcrd_decode
  import hcrd_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_PORTS = 3,
  parameter int IDX_W     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  port_idx
);
  localparam int PORT_END = PORT_WORD0 + NUM_PORTS;

  int unsigned word;

  always_comb begin
    word     = int'(addr[ADDR_W-1:2]);
    sel      = SEL_NONE;
    port_idx = '0;
    if (addr[1:0] != 2'b00) begin
      sel = SEL_NONE;
    end else if (word >= PORT_WORD0 && word < PORT_END) begin
      sel      = SEL_PORT;
      port_idx = IDX_W'(word - PORT_WORD0);
    end else begin
      case (word)
        0:       sel = SEL_REV;
        1:       sel = SEL_CTL;
        2:       sel = SEL_CMD;
        3:       sel = SEL_ISTAT;
        4, 5:    sel = SEL_IMASK;
        6:       sel = SEL_HCCA;
        7:       sel = SEL_PCUR;
        8:       sel = SEL_CHEAD;
        9:       sel = SEL_CCUR;
        10:      sel = SEL_BHEAD;
        11:      sel = SEL_BCUR;
        12:      sel = SEL_DONE;
        13:      sel = SEL_FINT;
        14:      sel = SEL_FREM;
        15:      sel = SEL_FNUM;
        16:      sel = SEL_PSTART;
        17:      sel = SEL_LSTH;
        18:      sel = SEL_HDA;
        19:      sel = SEL_HDB;
        20:      sel = SEL_HSTAT;
        24:      sel = SEL_XSTAT;
        25:      sel = SEL_XRST;
        26:      sel = SEL_XMASK;
        27:      sel = SEL_XTEST;
        default: sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/hcrd_mux.sv
module hcrd_mux
  import hcrd_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int IDX_W     = 2
) (
  input  sel_e                        sel,
  input  logic [IDX_W-1:0]            port_idx,
  input  logic [DATA_W-1:0]           ctl,
  input  logic [DATA_W-1:0]           cmd_status,
  input  logic [DATA_W-1:0]           int_status,
  input  logic [DATA_W-1:0]           int_mask,
  input  logic [DATA_W-1:0]           hcca_base,
  input  logic [DATA_W-1:0]           per_cur_ed,
  input  logic [DATA_W-1:0]           ctrl_head_ed,
  input  logic [DATA_W-1:0]           ctrl_cur_ed,
  input  logic [DATA_W-1:0]           bulk_head_ed,
  input  logic [DATA_W-1:0]           bulk_cur_ed,
  input  logic [DATA_W-1:0]           done_head,
  input  logic                        fi_toggle,
  input  logic [FMPS_W-1:0]           fi_max_pkt,
  input  logic [FI_W-1:0]             fi_interval,
  input  logic [DATA_W-1:0]           frame_remaining,
  input  logic [DATA_W-1:0]           frame_number,
  input  logic [DATA_W-1:0]           periodic_start,
  input  logic [DATA_W-1:0]           ls_threshold,
  input  logic [DATA_W-1:0]           hub_desc_a,
  input  logic [DATA_W-1:0]           hub_desc_b,
  input  logic [DATA_W-1:0]           hub_status,
  input  logic [NUM_PORTS*DATA_W-1:0] port_status,
  input  logic [DATA_W-1:0]           ext_status,
  input  logic [DATA_W-1:0]           ext_reset,
  input  logic [DATA_W-1:0]           ext_mask,
  input  logic [DATA_W-1:0]           ext_test,
  output logic [DATA_W-1:0]           raw
);
  localparam int GAP_W = DATA_W - 1 - FMPS_W - FI_W;

  logic [DATA_W-1:0] port_arr [NUM_PORTS];
  logic [DATA_W-1:0] port_word;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    assign port_arr[g] = port_status[g*DATA_W +: DATA_W];
  end

  always_comb begin
    port_word = NO_REG;
    if (int'(port_idx) < NUM_PORTS) begin
      port_word = port_arr[port_idx];
      port_word[PWR_BIT] = 1'b1;
    end
  end

  always_comb begin
    case (sel)
      SEL_REV:    raw = REV_VALUE;
      SEL_CTL:    raw = ctl;
      SEL_CMD:    raw = cmd_status;
      SEL_ISTAT:  raw = int_status;
      SEL_IMASK:  raw = int_mask;
      SEL_HCCA:   raw = hcca_base;
      SEL_PCUR:   raw = per_cur_ed;
      SEL_CHEAD:  raw = ctrl_head_ed;
      SEL_CCUR:   raw = ctrl_cur_ed;
      SEL_BHEAD:  raw = bulk_head_ed;
      SEL_BCUR:   raw = bulk_cur_ed;
      SEL_DONE:   raw = done_head;
      SEL_FINT:   raw = {fi_toggle, fi_max_pkt, {GAP_W{1'b0}}, fi_interval};
      SEL_FREM:   raw = frame_remaining;
      SEL_FNUM:   raw = frame_number;
      SEL_PSTART: raw = periodic_start;
      SEL_LSTH:   raw = ls_threshold;
      SEL_HDA:    raw = hub_desc_a;
      SEL_HDB:    raw = hub_desc_b;
      SEL_HSTAT:  raw = hub_status;
      SEL_PORT:   raw = port_word;
      SEL_XSTAT:  raw = ext_status & ext_mask;
      SEL_XRST:   raw = ext_reset;
      SEL_XMASK:  raw = ext_mask;
      SEL_XTEST:  raw = ext_test;
      default:    raw = NO_REG;
    endcase
  end
endmodule

// File: rtl/hcrd_swap.sv
module hcrd_swap
  import hcrd_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NBYTES = DATA_W / 8;

  if (BIG_ENDIAN) begin : g_swap
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign dout[b*8 +: 8] = din[(NBYTES-1-b)*8 +: 8];
    end
  end else begin : g_pass
    assign dout = din;
  end
endmodule

// File: rtl/hcrd_read_decoder.sv
module hcrd_read_decoder
  import hcrd_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_PORTS  = 3,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [DATA_W-1:0]           rsp_data,
  input  logic [DATA_W-1:0]           ctl,
  input  logic [DATA_W-1:0]           cmd_status,
  input  logic [DATA_W-1:0]           int_status,
  input  logic [DATA_W-1:0]           int_mask,
  input  logic [DATA_W-1:0]           hcca_base,
  input  logic [DATA_W-1:0]           per_cur_ed,
  input  logic [DATA_W-1:0]           ctrl_head_ed,
  input  logic [DATA_W-1:0]           ctrl_cur_ed,
  input  logic [DATA_W-1:0]           bulk_head_ed,
  input  logic [DATA_W-1:0]           bulk_cur_ed,
  input  logic [DATA_W-1:0]           done_head,
  input  logic                        fi_toggle,
  input  logic [FMPS_W-1:0]           fi_max_pkt,
  input  logic [FI_W-1:0]             fi_interval,
  input  logic [DATA_W-1:0]           frame_remaining,
  input  logic [DATA_W-1:0]           frame_number,
  input  logic [DATA_W-1:0]           periodic_start,
  input  logic [DATA_W-1:0]           ls_threshold,
  input  logic [DATA_W-1:0]           hub_desc_a,
  input  logic [DATA_W-1:0]           hub_desc_b,
  input  logic [DATA_W-1:0]           hub_status,
  input  logic [NUM_PORTS*DATA_W-1:0] port_status,
  input  logic [DATA_W-1:0]           ext_status,
  input  logic [DATA_W-1:0]           ext_reset,
  input  logic [DATA_W-1:0]           ext_mask,
  input  logic [DATA_W-1:0]           ext_test
);
  localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int PORT_END  = PORT_WORD0 + NUM_PORTS;
  localparam int FIRST_GAP = (PORT_END > EXT_LAST + 1) ? PORT_END : EXT_LAST + 1;
  localparam int PWR_POS   = BIG_ENDIAN ? (8 * (3 - PWR_BIT / 8) + PWR_BIT % 8) : PWR_BIT;

  sel_e              sel;
  logic [IDX_W-1:0]  port_idx;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] ordered;
  logic              accept;

  hcrd_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_decode (
    .addr(req_addr), .sel(sel), .port_idx(port_idx)
  );

  hcrd_mux #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_mux (
    .sel(sel), .port_idx(port_idx),
    .ctl(ctl), .cmd_status(cmd_status), .int_status(int_status), .int_mask(int_mask),
    .hcca_base(hcca_base), .per_cur_ed(per_cur_ed), .ctrl_head_ed(ctrl_head_ed),
    .ctrl_cur_ed(ctrl_cur_ed), .bulk_head_ed(bulk_head_ed), .bulk_cur_ed(bulk_cur_ed),
    .done_head(done_head), .fi_toggle(fi_toggle), .fi_max_pkt(fi_max_pkt),
    .fi_interval(fi_interval), .frame_remaining(frame_remaining),
    .frame_number(frame_number), .periodic_start(periodic_start),
    .ls_threshold(ls_threshold), .hub_desc_a(hub_desc_a), .hub_desc_b(hub_desc_b),
    .hub_status(hub_status), .port_status(port_status), .ext_status(ext_status),
    .ext_reset(ext_reset), .ext_mask(ext_mask), .ext_test(ext_test), .raw(raw)
  );

  hcrd_swap #(.BIG_ENDIAN(BIG_ENDIAN)) u_swap (.din(raw), .dout(ordered));

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= ordered;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  int unsigned chk_word;
  assign chk_word = int'(req_addr[ADDR_W-1:2]);

  // R11: response follows acceptance by one cycle
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R11: a stalled response keeps its data
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R1: misaligned reads return all ones
  p_misalign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_addr[1:0] != 2'b00) |=> (rsp_data == NO_REG));

  // R9: offsets past every mapped word return all ones
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_addr[1:0] == 2'b00 && chk_word >= FIRST_GAP) |=> (rsp_data == NO_REG));

  // R6: port reads always show the power bit
  p_port_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_addr[1:0] == 2'b00 && chk_word >= PORT_WORD0 && chk_word < PORT_END)
    |=> rsp_data[PWR_POS]);
endmodule

// File: tb/hcrd_read_decoder_tb.sv
module hcrd_read_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int NP_A = 3;
  localparam int NP_B = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] r [28];
  logic fi_toggle;
  logic [14:0] fi_max_pkt;
  logic [13:0] fi_interval;
  logic [15*32-1:0] ports_all;
  logic ready_a, ready_b, valid_a, valid_b;
  logic [31:0] data_a, data_b;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  hcrd_read_decoder #(.ADDR_W(AW), .NUM_PORTS(NP_A), .BIG_ENDIAN(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready_a),
    .req_addr(req_addr), .rsp_valid(valid_a), .rsp_ready(rsp_ready), .rsp_data(data_a),
    .ctl(r[1]), .cmd_status(r[2]), .int_status(r[3]), .int_mask(r[4]), .hcca_base(r[6]),
    .per_cur_ed(r[7]), .ctrl_head_ed(r[8]), .ctrl_cur_ed(r[9]), .bulk_head_ed(r[10]),
    .bulk_cur_ed(r[11]), .done_head(r[12]), .fi_toggle(fi_toggle), .fi_max_pkt(fi_max_pkt),
    .fi_interval(fi_interval), .frame_remaining(r[14]), .frame_number(r[15]),
    .periodic_start(r[16]), .ls_threshold(r[17]), .hub_desc_a(r[18]), .hub_desc_b(r[19]),
    .hub_status(r[20]), .port_status(ports_all[NP_A*32-1:0]), .ext_status(r[24]),
    .ext_reset(r[25]), .ext_mask(r[26]), .ext_test(r[27])
  );

  hcrd_read_decoder #(.ADDR_W(AW), .NUM_PORTS(NP_B), .BIG_ENDIAN(1'b1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready_b),
    .req_addr(req_addr), .rsp_valid(valid_b), .rsp_ready(rsp_ready), .rsp_data(data_b),
    .ctl(r[1]), .cmd_status(r[2]), .int_status(r[3]), .int_mask(r[4]), .hcca_base(r[6]),
    .per_cur_ed(r[7]), .ctrl_head_ed(r[8]), .ctrl_cur_ed(r[9]), .bulk_head_ed(r[10]),
    .bulk_cur_ed(r[11]), .done_head(r[12]), .fi_toggle(fi_toggle), .fi_max_pkt(fi_max_pkt),
    .fi_interval(fi_interval), .frame_remaining(r[14]), .frame_number(r[15]),
    .periodic_start(r[16]), .ls_threshold(r[17]), .hub_desc_a(r[18]), .hub_desc_b(r[19]),
    .hub_status(r[20]), .port_status(ports_all[NP_B*32-1:0]), .ext_status(r[24]),
    .ext_reset(r[25]), .ext_mask(r[26]), .ext_test(r[27])
  );

  function automatic logic [31:0] model(input logic [AW-1:0] a, input int np, input bit be);
    logic [31:0] v;
    int w;
    w = int'(a >> 2);
    if (a[1:0] != 2'b00) v = 32'hFFFF_FFFF;
    else if (w >= 21 && w < 21 + np) v = ports_all[(w-21)*32 +: 32] | 32'h0000_0100;
    else if (w == 0) v = 32'h10;
    else if (w == 5) v = r[4];
    else if (w == 13) v = {fi_toggle, fi_max_pkt, 2'b00, fi_interval};
    else if (w == 24) v = r[24] & r[26];
    else if (w <= 20 || (w >= 25 && w <= 27)) v = r[w];
    else v = 32'hFFFF_FFFF;
    if (be) v = {v[7:0], v[15:8], v[23:16], v[31:24]};
    return v;
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a, input int np);
    int w;
    w = int'(a >> 2);
    if (a[1:0] != 2'b00) return "R1";
    if (w >= 21 && w < 21 + np) return (w >= 24) ? "R7" : "R6";
    if (w == 0) return "R2";
    if (w == 4 || w == 5) return "R4";
    if (w == 13) return "R5";
    if (w >= 24 && w <= 27) return "R8";
    if (w <= 20) return "R3";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic shuffle_regs();
    for (int i = 0; i < 28; i++) r[i] = $urandom;
    for (int p = 0; p < 15; p++) ports_all[p*32 +: 32] = $urandom;
    fi_toggle = 1'($urandom);
    fi_max_pkt = 15'($urandom);
    fi_interval = 14'($urandom);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    req_addr = a; req_valid = 1'b1; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 valid", {31'b0, valid_a & valid_b}, 32'd1);
    check({tag_of(a, NP_A), " narrow"}, data_a, model(a, NP_A, 1'b0));
    check({tag_of(a, NP_B), " R10 wide"}, data_b, model(a, NP_B, 1'b1));
    shuffle_regs();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5EED_0042));
    shuffle_regs();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check("R12 valid", {30'b0, valid_a, valid_b}, 32'd0);
    check("R12 ready", {30'b0, ready_a, ready_b}, 32'd3);

    // directed: every word offset, then misaligned and far addresses
    for (int w = 0; w < 32; w++) do_read(AW'(w * 4));
    for (int k = 1; k < 4; k++) do_read(AW'(k));
    do_read(AW'(12'h0FFC));
    do_read(AW'(12'h0055));

    // R11: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_addr = AW'(4); req_valid = 1'b1;
    @(negedge clk);
    held = r[1];
    check("R11 first data", data_a, held);
    req_addr = AW'(13 * 4);
    r[1] = ~held;
    check("R11 ready low", {30'b0, ready_a, ready_b}, 32'd0);
    @(negedge clk);
    check("R11 stall valid", {31'b0, valid_a}, 32'd1);
    check("R11 stall hold", data_a, held);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 next data R5", data_a, model(AW'(13 * 4), NP_A, 1'b0));

    // random mix
    for (int i = 0; i < 500; i++) begin
      logic [AW-1:0] a;
      case ($urandom_range(0, 9))
        0:       a = AW'($urandom);
        1:       a = AW'($urandom_range(0, 40) * 4 + $urandom_range(1, 3));
        default: a = AW'($urandom_range(0, 40) * 4);
      endcase
      do_read(a);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule